// File: doc/BRIEF.md
# Programmable SPI Flash Command Engine

The engine runs one flash transaction that software describes in a set of register values. A transaction consists of up to five phases, and each phase can be left out: an opcode byte, an address, outgoing write bytes, dummy clocks, and incoming read bytes. The phases always run in that order. A start pulse samples every size field, the command word, the address, the write-data words and the chip-select controls into the engine. The engine then walks through the phases and hands one shift item at a time to an external serializer. An item is either a full byte or a 1, 2 or 4 bit group.

Each received byte is returned on a byte-lane write-back port so that the surrounding register file can assemble four read-data words. When the last item has been acknowledged, the engine raises a one-cycle completion pulse. The register file uses this pulse to set its ready flag and clear its start bit. The engine drives a chip-select line itself only when software has handed chip-select control to it. Otherwise all of its select outputs stay inactive and software keeps control of the line.

Top module: `spi_cmd_engine`

## Requirements
- R1: When `cfg_i[10]` is 1, the first item is an 8-bit transfer of `cmd_i[7:0]`. When it is 0, no opcode item is sent.
- R2: `cfg_i[13:11]` sets the number of address bytes, and values 5 to 7 count as 4. The bytes come from `addr_i` and go out most significant first, so 3 bytes send `addr_i[23:16]`, then `[15:8]`, then `[7:0]`.
- R3: `cfg_i[20:16]` sets the number of write bytes. Byte i is taken from word w of `wdata_i` (word w is `wdata_i[32w+31:32w]`) at bit offset 8·(i mod 4). Here w = i/4 for i < 16, and w = 3 for every i of 16 or more.
- R4: `cfg_i[23:21]` sets the number of dummy bytes. Each dummy byte is sent as 8/W groups of W = 1 << `cfg_i[7:6]` bits, least significant group first. Each group appears in the low W bits of `shift_data_o`, `shift_len_o` equals W, and all bits above W are zero.
- R5: The first dummy byte comes from `cmd_i[15:8]`, the second from `cmd_i[23:16]`, and every later one from `cmd_i[31:24]`.
- R6: `cfg_i[28:24]` sets the number of read bytes, and each read byte is an 8-bit item with zero data. For a read byte of index i < 16, the engine pulses `rd_wr_o` one cycle after its acknowledge, with `rd_word_o` = i/4, `rd_lane_o` = i mod 4 and the received byte on `rd_data_o`. Bytes with index 16 or more are still shifted but produce no write-back.
- R7: While items are being shifted, if `sw_cs_i` = 1 and `dev_sel_i` < NCS, then `cs_n_o[dev_sel_i]` is low and every other bit is high. In all other cases, including an out-of-range device number, all `cs_n_o` bits are high and the phases still run.
- R8: `done_o` pulses for exactly one cycle after the last acknowledge. If every phase is empty, it pulses in the cycle after start instead. `busy_o` is high from the cycle after start through the `done_o` cycle.
- R9: The phases follow the order opcode, address, write, dummy, read. Each item is held with `shift_valid_o` high and stable data and length until `shift_done_i` is seen.
- R10: A start pulse while `busy_o` is high is ignored. Input changes after start do not affect the running transaction.
- R11: After reset, `busy_o`, `done_o`, `shift_valid_o` and `rd_wr_o` are low and all `cs_n_o` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken when idle |
| cfg_i | input | 32 | Phase configuration word |
| cmd_i | input | 32 | Opcode and dummy source bytes |
| addr_i | input | 32 | Address value |
| wdata_i | input | 128 | Four write-data words, word 0 in the low bits |
| sw_cs_i | input | 1 | 1: engine controls the chip select |
| dev_sel_i | input | 2 | Target device number |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Completion pulse (set ready, clear start) |
| shift_valid_o | output | 1 | Shift item pending |
| shift_len_o | output | 4 | Bits in the item: 1, 2, 4 or 8 |
| shift_data_o | output | 8 | Outgoing bits, LSB-aligned |
| shift_done_i | input | 1 | Serializer acknowledge, one cycle |
| shift_rdata_i | input | 8 | Byte received with the acknowledge |
| rd_wr_o | output | 1 | Read-data byte write strobe |
| rd_word_o | output | 2 | Read-data word index |
| rd_lane_o | output | 2 | Byte lane within the word |
| rd_data_o | output | 8 | Received byte |
| cs_n_o | output | NCS | Active-low chip selects |

## Verification
The hardest cases to reach from the ports are the clamped and discarded indexes. These are write bytes 16 and 17 reusing the last word, read bytes 16 and 17 producing no write-back, and an address size above four. The stimulus reaches them with transactions of 18 write bytes, 18 read bytes and an address field of 7. The scoreboard predicts every item in order, so a missing, extra or reordered item is caught. One transaction also applies a second start pulse and new inputs in the middle of its run, to show that neither changes the item stream or the number of completions.

// File: rtl/sce_pkg.sv
package sce_pkg;
  localparam int NWORD   = 4;
  localparam int WORD_W  = 32;
  localparam int WDATA_W = NWORD * WORD_W;
  localparam int KEEP_N  = NWORD * (WORD_W / 8);

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_OPC  = 3'd1,
    PH_ADR  = 3'd2,
    PH_WR   = 3'd3,
    PH_DMY  = 3'd4,
    PH_RD   = 3'd5,
    PH_FIN  = 3'd6
  } phase_e;

  typedef struct packed {
    logic       opc_en;
    logic [2:0] adr_n;
    logic [4:0] wr_n;
    logic [2:0] dmy_n;
    logic [4:0] rd_n;
    logic [1:0] dbw;
  } shape_t;

  function automatic shape_t decode_shape(logic [31:0] cfg);
    shape_t s;
    s.opc_en = cfg[10];
    s.adr_n  = (cfg[13:11] > 3'd4) ? 3'd4 : cfg[13:11];
    s.wr_n   = cfg[20:16];
    s.dmy_n  = cfg[23:21];
    s.rd_n   = cfg[28:24];
    s.dbw    = cfg[7:6];
    return s;
  endfunction
endpackage

// File: rtl/sce_seq.sv
module sce_seq
  import sce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  shape_t     live_i,
  input  shape_t     job_i,
  input  logic       ack_i,
  output phase_e     phase_o,
  output logic [4:0] idx_o,
  output logic [2:0] grp_o
);
  phase_e     ph_q, ph_d;
  logic [4:0] idx_q, idx_d;
  logic [2:0] grp_q, grp_d;
  logic [2:0] last_grp;
  logic       byte_end;

  function automatic logic [4:0] plen(phase_e p, shape_t s);
    logic [4:0] n;
    unique case (p)
      PH_OPC:  n = {4'd0, s.opc_en};
      PH_ADR:  n = {2'd0, s.adr_n};
      PH_WR:   n = s.wr_n;
      PH_DMY:  n = {2'd0, s.dmy_n};
      PH_RD:   n = s.rd_n;
      default: n = 5'd0;
    endcase
    return n;
  endfunction

  function automatic phase_e next_after(phase_e p, shape_t s);
    phase_e r;
    logic   hit;
    r   = PH_FIN;
    hit = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      if (!hit && (k > int'(p)) && (plen(phase_e'(k), s) != 5'd0)) begin
        r   = phase_e'(k);
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  assign last_grp = 3'd7 >> job_i.dbw;
  assign byte_end = (ph_q != PH_DMY) || (grp_q == last_grp);

  always_comb begin
    ph_d  = ph_q;
    idx_d = idx_q;
    grp_d = grp_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d  = next_after(PH_IDLE, live_i);
          idx_d = 5'd0;
          grp_d = 3'd0;
        end
      end
      PH_FIN: ph_d = PH_IDLE;
      default: begin
        if (ack_i) begin
          if (!byte_end) begin
            grp_d = grp_q + 3'd1;
          end else begin
            grp_d = 3'd0;
            if (({1'b0, idx_q} + 6'd1) < {1'b0, plen(ph_q, job_i)}) begin
              idx_d = idx_q + 5'd1;
            end else begin
              idx_d = 5'd0;
              ph_d  = next_after(ph_q, job_i);
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= 5'd0;
      grp_q <= 3'd0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
      grp_q <= grp_d;
    end
  end

  assign phase_o = ph_q;
  assign idx_o   = idx_q;
  assign grp_o   = grp_q;

  // R9: phases only move forward within a transaction
  p_phase_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && $past(ph_q) != PH_IDLE) |-> (ph_q >= $past(ph_q)));

  // R9: no progress without an acknowledge
  p_wait_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && ph_q != PH_FIN && !ack_i)
      |=> ($stable(ph_q) && $stable(idx_q) && $stable(grp_q)));
endmodule

// File: rtl/sce_txmux.sv
module sce_txmux
  import sce_pkg::*;
(
  input  phase_e             phase_i,
  input  logic [4:0]         idx_i,
  input  logic [2:0]         grp_i,
  input  logic [2:0]         adr_n_i,
  input  logic [1:0]         dbw_i,
  input  logic [31:0]        cmd_i,
  input  logic [31:0]        addr_i,
  input  logic [WDATA_W-1:0] wdata_i,
  output logic [7:0]         data_o,
  output logic [3:0]         len_o
);
  localparam logic [4:0] REUSE_FROM = 5'(KEEP_N);
  localparam logic [1:0] LAST_WORD  = 2'(NWORD - 1);

  logic [2:0] adr_sel;
  logic [1:0] wr_word;
  logic [7:0] dmy_src;
  logic [2:0] dmy_shamt;
  logic [7:0] dmy_mask;

  always_comb begin
    adr_sel   = adr_n_i - 3'd1 - idx_i[2:0];
    wr_word   = (idx_i >= REUSE_FROM) ? LAST_WORD : idx_i[3:2];
    dmy_src   = (idx_i == 5'd0) ? cmd_i[15:8] :
                (idx_i == 5'd1) ? cmd_i[23:16] : cmd_i[31:24];
    dmy_shamt = 3'(grp_i << dbw_i);
    dmy_mask  = 8'hFF >> (4'd8 - (4'd1 << dbw_i));
    data_o    = 8'h00;
    len_o     = 4'd8;
    unique case (phase_i)
      PH_OPC: data_o = cmd_i[7:0];
      PH_ADR: data_o = addr_i[{adr_sel[1:0], 3'b000} +: 8];
      PH_WR:  data_o = wdata_i[{wr_word, idx_i[1:0], 3'b000} +: 8];
      PH_DMY: begin
        len_o  = 4'd1 << dbw_i;
        data_o = (dmy_src >> dmy_shamt) & dmy_mask;
      end
      default: data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/sce_csdec.sv
module sce_csdec #(
  parameter int NCS   = 2,
  parameter int DEV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DEV_W-1:0] dev_i,
  output logic [NCS-1:0]   cs_n_o
);
  for (genvar c = 0; c < NCS; c++) begin : g_cs
    assign cs_n_o[c] = !(en_i && (32'(dev_i) == c));
  end

  // R7: never more than one device selected
  p_cs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n_o) <= 1);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import sce_pkg::*;
#(
  parameter int NCS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [31:0]        cfg_i,
  input  logic [31:0]        cmd_i,
  input  logic [31:0]        addr_i,
  input  logic [WDATA_W-1:0] wdata_i,
  input  logic               sw_cs_i,
  input  logic [1:0]         dev_sel_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               shift_valid_o,
  output logic [3:0]         shift_len_o,
  output logic [7:0]         shift_data_o,
  input  logic               shift_done_i,
  input  logic [7:0]         shift_rdata_i,
  output logic               rd_wr_o,
  output logic [1:0]         rd_word_o,
  output logic [1:0]         rd_lane_o,
  output logic [7:0]         rd_data_o,
  output logic [NCS-1:0]     cs_n_o
);
  localparam int         DEV_W    = 2;
  localparam logic [4:0] KEEP_LIM = 5'(KEEP_N);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  phase_e       phase;
  logic [4:0]   idx;
  logic [2:0]   grp;
  logic         load;
  shape_t       live_shape, job_q;
  logic [31:0]  cmd_q, addr_q;
  logic [WDATA_W-1:0] wdata_q;
  logic         swcs_q;
  logic [DEV_W-1:0] dev_q;
  logic         wb_we_d, wb_we_q;
  logic [1:0]   wb_word_q, wb_lane_q;
  logic [7:0]   wb_data_q;

  assign live_shape = decode_shape(cfg_i);
  assign load       = start_i && (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      job_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      swcs_q  <= 1'b0;
      dev_q   <= '0;
    end else if (load) begin
      job_q   <= live_shape;
      cmd_q   <= cmd_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      swcs_q  <= sw_cs_i;
      dev_q   <= dev_sel_i;
    end
  end

  sce_seq i_seq (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start_i (start_i),
    .live_i  (live_shape),
    .job_i   (job_q),
    .ack_i   (shift_done_i),
    .phase_o (phase),
    .idx_o   (idx),
    .grp_o   (grp)
  );

  sce_txmux i_txmux (
    .phase_i (phase),
    .idx_i   (idx),
    .grp_i   (grp),
    .adr_n_i (job_q.adr_n),
    .dbw_i   (job_q.dbw),
    .cmd_i   (cmd_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .data_o  (shift_data_o),
    .len_o   (shift_len_o)
  );

  assign busy_o        = (phase != PH_IDLE);
  assign done_o        = (phase == PH_FIN);
  assign shift_valid_o = (phase != PH_IDLE) && (phase != PH_FIN);

  sce_csdec #(.NCS(NCS), .DEV_W(DEV_W)) i_csdec (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .en_i   (shift_valid_o && swcs_q),
    .dev_i  (dev_q),
    .cs_n_o (cs_n_o)
  );

  // read-data write-back, one cycle after the acknowledge
  assign wb_we_d = shift_done_i && (phase == PH_RD) && (idx < KEEP_LIM);

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      wb_we_q   <= 1'b0;
      wb_word_q <= 2'd0;
      wb_lane_q <= 2'd0;
      wb_data_q <= 8'd0;
    end else begin
      wb_we_q <= wb_we_d;
      if (wb_we_d) begin
        wb_word_q <= idx[3:2];
        wb_lane_q <= idx[1:0];
        wb_data_q <= shift_rdata_i;
      end
    end
  end

  assign rd_wr_o   = wb_we_q;
  assign rd_word_o = wb_word_q;
  assign rd_lane_o = wb_lane_q;
  assign rd_data_o = wb_data_q;

  // R8: completion is followed by idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done_o |=> !busy_o);

  // R7: no select outside the shifting window
  p_cs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !shift_valid_o |-> (&cs_n_o));

  // R9: a pending item is held until acknowledged
  p_item_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (shift_valid_o && !shift_done_i)
      |=> (shift_valid_o && $stable(shift_data_o) && $stable(shift_len_o)));

  // R4: legal group width, no bits above it
  p_group_fit_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    shift_valid_o |-> ($onehot(shift_len_o) && ((16'(shift_data_o) >> shift_len_o) == 16'd0)));

  // R10: captured transaction is frozen while busy
  p_job_frozen_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (busy_o && $past(busy_o)) |-> ($stable(job_q) && $stable(cmd_q) && $stable(dev_q)));
endmodule

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
  localparam int NCS = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [31:0]  cfg_i = '0, cmd_i = '0, addr_i = '0;
  logic [127:0] wdata_i = '0;
  logic         sw_cs_i = 1'b0;
  logic [1:0]   dev_sel_i = '0;
  logic         busy_o, done_o, shift_valid_o;
  logic [3:0]   shift_len_o;
  logic [7:0]   shift_data_o;
  logic         shift_done_i = 1'b0;
  logic [7:0]   shift_rdata_i = '0;
  logic         rd_wr_o;
  logic [1:0]   rd_word_o, rd_lane_o;
  logic [7:0]   rd_data_o;
  logic [NCS-1:0] cs_n_o;

  always #4 clk = ~clk;

  spi_cmd_engine #(.NCS(NCS)) i_spi_cmd_engine (.*);

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0;
  int exp_no = 0, dev_no = 0;
  logic [NCS-1:0] exp_cs_n = '1;
  bit finished = 0;

  logic [11:0] xq[$];   // {len, data}
  logic [11:0] wq[$];   // {word, lane, data}

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rxf(int n);
    return 8'(n * 29 + 8'h47);
  endfunction

  // serializer model and item scoreboard
  initial begin
    bit acked = 0;
    forever begin
      @(negedge clk);
      if (acked) begin
        shift_done_i = 1'b0;
        acked = 0;
      end else if (shift_valid_o) begin
        if (xq.size() == 0) begin
          chk(0, "R9 unexpected item", {20'd0, shift_len_o, shift_data_o}, 0);
        end else begin
          logic [11:0] e;
          e = xq.pop_front();
          chk({shift_len_o, shift_data_o} == e, "R1-order R9 item", {shift_len_o, shift_data_o}, e);
        end
        chk(cs_n_o == exp_cs_n, "R7 select", cs_n_o, exp_cs_n);
        shift_rdata_i = rxf(dev_no);
        dev_no++;
        shift_done_i = 1'b1;
        acked = 1;
      end
    end
  end

  // write-back and completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) done_cnt++;
      if (rd_wr_o) begin
        if (wq.size() == 0) begin
          chk(0, "R6 unexpected write-back", {rd_word_o, rd_lane_o, rd_data_o}, 0);
        end else begin
          logic [11:0] e;
          e = wq.pop_front();
          chk({rd_word_o, rd_lane_o, rd_data_o} == e, "R6 write-back", {rd_word_o, rd_lane_o, rd_data_o}, e);
        end
      end
    end
  end

  function automatic logic [31:0] mk_cfg(bit opc, int adr, int wr, int dmy, int dbw, int rd);
    return (32'(opc) << 10) | (32'(adr) << 11) | (32'(wr) << 16) |
           (32'(dmy) << 21) | (32'(dbw) << 6) | (32'(rd) << 24);
  endfunction

  task automatic push_x(int len, logic [7:0] d);
    xq.push_back({4'(len), d});
    exp_no++;
  endtask

  // driver: predict items from the requirements, then start
  task automatic run(logic [31:0] cfg, logic [31:0] cmd, logic [31:0] addr,
                     bit swcs, logic [1:0] dev, bit poke);
    int na, nw, nd, wd, nr, d0;
    na = (cfg[13:11] > 4) ? 4 : int'(cfg[13:11]);
    nw = int'(cfg[20:16]);
    nd = int'(cfg[23:21]);
    wd = 1 << cfg[7:6];
    nr = int'(cfg[28:24]);
    if (cfg[10]) push_x(8, cmd[7:0]);                          // R1
    for (int b = na - 1; b >= 0; b--) push_x(8, addr[8*b +: 8]); // R2
    for (int i = 0; i < nw; i++) begin                          // R3
      int w;
      w = (i >= 16) ? 3 : i / 4;
      push_x(8, wdata_i[32*w + 8*(i%4) +: 8]);
    end
    for (int j = 0; j < nd; j++) begin                          // R4, R5
      logic [7:0] src;
      src = (j == 0) ? cmd[15:8] : (j == 1) ? cmd[23:16] : cmd[31:24];
      for (int g = 0; g < 8 / wd; g++)
        push_x(wd, 8'((src >> (g * wd)) & ((1 << wd) - 1)));
    end
    for (int i = 0; i < nr; i++) begin                          // R6
      if (i < 16) wq.push_back({2'(i / 4), 2'(i % 4), rxf(exp_no)});
      push_x(8, 8'h00);
    end
    exp_cs_n = (swcs && dev < NCS) ? ~(NCS'(1) << dev) : '1;
    d0 = done_cnt;
    @(negedge clk);
    cfg_i = cfg; cmd_i = cmd; addr_i = addr; sw_cs_i = swcs; dev_sel_i = dev;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      cfg_i = mk_cfg(1, 4, 5, 2, 0, 3); cmd_i = ~cmd; addr_i = ~addr;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(xq.size() == 0, "R10 all items consumed", xq.size(), 0);
    chk(wq.size() == 0, "R6 all write-backs seen", wq.size(), 0);
    chk(done_cnt == d0 + 1, "R8 one completion", done_cnt - d0, 1);
    chk(&cs_n_o, "R7 released after run", cs_n_o, '1);
  endtask

  initial begin
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++)
        wdata_i[32*w + 8*b +: 8] = 8'(8'h11 * (w + 1) + b * 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!busy_o, "R11 busy", busy_o, 0);
    chk(!done_o, "R11 done", done_o, 0);
    chk(!shift_valid_o, "R11 valid", shift_valid_o, 0);
    chk(!rd_wr_o, "R11 write-back", rd_wr_o, 0);
    chk(&cs_n_o, "R11 selects", cs_n_o, '1);
    // R1 R2 R3 R4 R6 R7: full transaction, device 1
    run(mk_cfg(1, 3, 2, 1, 0, 4), 32'h5AC3960B, 32'h00123456, 1, 2'd1, 0);
    // R2 R3 R5: 4 addr bytes, 18 write bytes (reuse), 3 dummy at 2 bits, software CS
    run(mk_cfg(0, 4, 18, 3, 1, 0), 32'hE4B2719D, 32'hA1B2C3D4, 0, 2'd0, 0);
    // R2 clamp, R6 discard, R7 out-of-range device
    run(mk_cfg(1, 7, 0, 2, 2, 18), 32'h3C5AF00F, 32'h89ABCDEF, 1, 2'd3, 0);
    // R8 empty transaction
    run(32'h0, 32'h0, 32'h0, 1, 2'd0, 0);
    // R10 ignored start, R4 full-byte dummy group
    run(mk_cfg(0, 1, 1, 1, 3, 2), 32'h00A50000, 32'h00000077, 1, 2'd0, 1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule